// File: doc/BRIEF.md
# Flow-Through Synchronous Burst Static RAM

This block is a cycle-accurate model of a synchronous static RAM with flow-through reads and four-beat bursts. Control inputs are sampled on the rising clock edge. The array is read combinationally from the registered address, so read data for a captured address appears in the cycle right after the capturing edge, with no extra output register. The default array holds 1024 words of 36 bits, split into four 9-bit byte lanes.

A cycle begins a burst when either of two address strobes is asserted. The processor strobe always starts a read. The controller strobe can start a read or a write. Once a burst has begun, an advance input steps a 2-bit counter over the two low address bits in interleaved or linear order, or holds the current address. Three chip enables select the device when a burst begins. A deselect lasts until the next burst begins. The tri-state pads are modelled as a data bus plus a valid flag. An asynchronous output enable and a sleep input gate that flag.

Top module: `fts_sram`

## Requirements
- R1: A read burst that begins at address A at a clock edge shows the word stored at A on `rd_data`, with `rd_valid` high, in the cycle that follows that edge, provided `oe_n` is low.
- R2: While `oe_n` is high, `rd_valid` is low and `rd_data` is all zeros. This takes effect combinationally, without waiting for a clock edge.
- R3: With `ilv_mode` high, beat k of a burst (k = 0..3, counted from the start address) uses low address bits equal to the start's low two bits XOR k.
- R4: With `ilv_mode` low, beat k uses low address bits equal to the start's low two bits plus k, modulo 4. In both orders the bits above bit 1 never change inside a burst, so the burst wraps within its aligned group of four.
- R5: When neither strobe is low and `adv_n` is low, the burst moves to its next address. When `adv_n` is high, it stays on the current address.
- R6: A burst begins from `addr` when `pstb_n` is low, or when `pstb_n` is high and `cstb_n` is low.
- R7: A burst begun by `pstb_n` low is always a read. Every write enable is ignored in that cycle, and the array is left unchanged.
- R8: A cycle is a write when `gwr_n` is low, which writes all four lanes. It is also a write when `bwe_n` is low and at least one bit of `lane_we_n` is low; then only the lanes whose bit is low are written. Lane i holds data bits 9i+8 down to 9i. With `bwe_n` high and `gwr_n` high, or with all `lane_we_n` bits high, the cycle is a read. A write can begin a burst only through `cstb_n`; continue and suspend cycles may write.
- R9: If `ce0_n` is high, `ce1` is low or `ce2_n` is high when a strobe begins a burst, the device becomes deselected. In the next cycle `rd_valid` is low. Continue cycles neither read nor write until a burst begins again.
- R10: In the cycle after a write edge, `rd_valid` is low.
- R11: While `sleep` is high, `rd_valid` is low and clock edges are ignored. The first edge after `sleep` falls is also ignored. Array contents and burst state are kept across sleep.
- R12: After reset the device is deselected and `rd_valid` is low until a burst begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | External word address |
| wr_data | input | LANES*LANE_W | Write data |
| ce0_n | input | 1 | Chip enable, active low |
| ce1 | input | 1 | Chip enable, active high |
| ce2_n | input | 1 | Chip enable, active low |
| pstb_n | input | 1 | Processor address strobe, active low |
| cstb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gwr_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| lane_we_n | input | LANES | Per-lane write enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| ilv_mode | input | 1 | Burst order: 1 interleaved, 0 linear |
| sleep | input | 1 | Power-down request, active high |
| rd_data | output | LANES*LANE_W | Read data, zero when not valid |
| rd_valid | output | 1 | High when the model would drive its pads |

## Verification
A wrong burst counter or a wrong start address shows up as a wrong word on `rd_data` in the very cycle after the faulty edge, because nothing is pipelined between the address register and the output. A wrong write decision, such as a write started by the processor strobe or one landing on the wrong lanes, changes array contents. That only shows at the ports when the bench reads the location back, so every write-related check is followed by a read burst over the same address. A lost deselect or sleep state shows within one cycle as `rd_valid` high when it must be low.

// File: rtl/fts_pkg.sv
package fts_pkg;
  typedef enum logic [1:0] {
    ST_DESEL = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } fts_state_e;

  function automatic logic [1:0] beat_lo(input logic [1:0] start,
                                          input logic [1:0] k,
                                          input logic       ilv);
    return ilv ? (start ^ k) : (start + k);
  endfunction
endpackage

// File: rtl/fts_ctrl.sv
module fts_ctrl
  import fts_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       act,
  input  logic       pstb_n,
  input  logic       cstb_n,
  input  logic       adv_n,
  input  logic       chip_en,
  input  logic       wr_req,
  output logic       load,
  output logic       step,
  output logic       wr_now,
  output fts_state_e state
);
  fts_state_e state_d;
  logic       beg;

  always_comb begin
    beg     = !pstb_n || !cstb_n;
    load    = act && beg && chip_en;
    step    = act && !beg && (state != ST_DESEL) && !adv_n;
    state_d = state;
    if (act) begin
      if (beg) begin
        if (!chip_en)            state_d = ST_DESEL;
        else if (pstb_n && wr_req) state_d = ST_WRITE;
        else                     state_d = ST_READ;
      end else if (state != ST_DESEL) begin
        state_d = wr_req ? ST_WRITE : ST_READ;
      end
    end
    wr_now = act && (state_d == ST_WRITE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   state <= ST_DESEL;
    else if (act) state <= state_d;
  end

  assert_proc_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (act && !pstb_n) |=> (state != ST_WRITE));
  assert_desel_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (act && (!pstb_n || !cstb_n) && !chip_en) |=> (state == ST_DESEL));
endmodule

// File: rtl/fts_burst.sv
module fts_burst
  import fts_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic              ilv,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [ADDR_W-1:0] nxt_addr
);
  logic [ADDR_W-1:0] base_q, base_d;
  logic [1:0]        k_q, k_d;

  always_comb begin
    base_d = base_q;
    k_d    = k_q;
    if (load) begin
      base_d = addr_in;
      k_d    = 2'd0;
    end else if (step) begin
      k_d = k_q + 2'd1;
    end
    cur_addr = {base_q[ADDR_W-1:2], beat_lo(base_q[1:0], k_q, ilv)};
    nxt_addr = {base_d[ADDR_W-1:2], beat_lo(base_d[1:0], k_d, ilv)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      k_q    <= '0;
    end else if (load || step) begin
      base_q <= base_d;
      k_q    <= k_d;
    end
  end

  assert_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cur_addr == $past(addr_in)));
  assert_suspend_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(cur_addr));
  assert_group_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (cur_addr[ADDR_W-1:2] == $past(cur_addr[ADDR_W-1:2])));
endmodule

// File: rtl/fts_array.sv
module fts_array #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        we_lane,
  input  logic [ADDR_W-1:0]       waddr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [ADDR_W-1:0]       raddr,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we_lane[g]) mem[waddr] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rdata[g*LANE_W +: LANE_W] = mem[raddr];
  end
endmodule

// File: rtl/fts_sram.sv
module fts_sram
  import fts_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wr_data,
  input  logic                    ce0_n,
  input  logic                    ce1,
  input  logic                    ce2_n,
  input  logic                    pstb_n,
  input  logic                    cstb_n,
  input  logic                    adv_n,
  input  logic                    gwr_n,
  input  logic                    bwe_n,
  input  logic [LANES-1:0]        lane_we_n,
  input  logic                    oe_n,
  input  logic                    ilv_mode,
  input  logic                    sleep,
  output logic [LANES*LANE_W-1:0] rd_data,
  output logic                    rd_valid
);
  localparam int DATA_W = LANES * LANE_W;

  logic              wake_q;
  logic              act, chip_en, wr_req;
  logic              load, step, wr_now;
  logic [LANES-1:0]  lane_sel, we_lane;
  logic [ADDR_W-1:0] cur_addr, nxt_addr;
  logic [DATA_W-1:0] arr_q;
  fts_state_e        state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_q <= 1'b0;
    else        wake_q <= sleep;
  end

  always_comb begin
    act     = !sleep && !wake_q;
    chip_en = !ce0_n && ce1 && !ce2_n;
    wr_req  = !gwr_n || (!bwe_n && !(&lane_we_n));
    if (!gwr_n)     lane_sel = '1;
    else if (!bwe_n) lane_sel = ~lane_we_n;
    else            lane_sel = '0;
    we_lane  = wr_now ? lane_sel : '0;
    rd_valid = (state == ST_READ) && !oe_n && !sleep;
    rd_data  = rd_valid ? arr_q : '0;
  end

  fts_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .act(act), .pstb_n(pstb_n), .cstb_n(cstb_n),
    .adv_n(adv_n), .chip_en(chip_en), .wr_req(wr_req), .load(load),
    .step(step), .wr_now(wr_now), .state(state)
  );

  fts_burst #(.ADDR_W(ADDR_W)) u_burst (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step), .ilv(ilv_mode),
    .addr_in(addr), .cur_addr(cur_addr), .nxt_addr(nxt_addr)
  );

  fts_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk(clk), .we_lane(we_lane), .waddr(nxt_addr), .wdata(wr_data),
    .raddr(cur_addr), .rdata(arr_q)
  );

  assert_sleep_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !rd_valid);
  assert_wr_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WRITE) |-> !rd_valid);
  assert_oe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (rd_data == '0));
endmodule

// File: tb/test_fts_sram.sv
module test_fts_sram;
  localparam int AW = 10;
  localparam int DW = 36;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] wr_data;
  logic          ce0_n, ce1, ce2_n, pstb_n, cstb_n, adv_n, gwr_n, bwe_n;
  logic [3:0]    lane_we_n;
  logic          oe_n, ilv_mode, sleep;
  logic [DW-1:0] rd_data;
  logic          rd_valid;

  int n_tests = 0;
  int n_fail  = 0;

  // reference model state
  logic [DW-1:0] m_mem [1024];
  bit            m_ok  [1024];
  bit            m_sel, m_wr, m_slp;
  logic [AW-1:0] m_base;
  int            m_k;

  always #5 clk = ~clk;

  fts_sram i_fts_sram (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_data(wr_data),
    .ce0_n(ce0_n), .ce1(ce1), .ce2_n(ce2_n), .pstb_n(pstb_n),
    .cstb_n(cstb_n), .adv_n(adv_n), .gwr_n(gwr_n), .bwe_n(bwe_n),
    .lane_we_n(lane_we_n), .oe_n(oe_n), .ilv_mode(ilv_mode),
    .sleep(sleep), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  function automatic logic [DW-1:0] pat(input int a);
    logic [9:0] v = 10'(a);
    return {v, v ^ 10'h3FF, v, 6'h2B};
  endfunction

  function automatic logic [AW-1:0] m_addr();
    logic [1:0] lo = m_base[1:0];
    logic [1:0] kk = 2'(m_k);
    logic [1:0] s  = ilv_mode ? (lo ^ kk) : (lo + kk);
    return {m_base[AW-1:2], s};
  endfunction

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    bit beg, wrq, en;
    logic [3:0] msk;
    logic [AW-1:0] a;
    if (!rst_n) begin
      m_sel = 0; m_wr = 0; m_slp = 0; m_k = 0; m_base = '0;
      return;
    end
    if (sleep || m_slp) begin
      m_slp = sleep;
      return;
    end
    beg = !pstb_n || !cstb_n;
    en  = !ce0_n && ce1 && !ce2_n;
    wrq = !gwr_n || (!bwe_n && lane_we_n != 4'hF);
    msk = !gwr_n ? 4'hF : (!bwe_n ? ~lane_we_n : 4'h0);
    if (beg) begin
      if (!en) begin
        m_sel = 0; m_wr = 0;
      end else begin
        m_sel = 1; m_base = addr; m_k = 0; m_wr = pstb_n && wrq;
      end
    end else if (m_sel) begin
      if (!adv_n) m_k = (m_k + 1) % 4;
      m_wr = wrq;
    end
    if (m_sel && m_wr) begin
      a = m_addr();
      for (int i = 0; i < 4; i++)
        if (msk[i]) m_mem[a][i*9 +: 9] = wr_data[i*9 +: 9];
      if (msk == 4'hF) m_ok[a] = 1;
    end
  endtask

  // one clock: model follows the edge, outputs compared at the falling edge
  task automatic tick();
    bit ev;
    logic [AW-1:0] a;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    ev = m_sel && !m_wr && !oe_n && !sleep && rst_n;
    chk("R1 model valid", {35'd0, rd_valid}, {35'd0, ev});
    a = m_addr();
    if (ev && m_ok[a]) chk("R1 model data", rd_data, m_mem[a]);
  endtask

  task automatic idle();
    pstb_n = 1; cstb_n = 1; adv_n = 1; gwr_n = 1; bwe_n = 1; lane_we_n = 4'hF;
    ce0_n = 0; ce1 = 1; ce2_n = 0;
  endtask

  task automatic prd(input int a);
    idle(); pstb_n = 0; addr = AW'(a); tick();
  endtask

  task automatic cont(input bit adv);
    idle(); adv_n = adv; tick();
  endtask

  initial begin
    rst_n = 0; addr = '0; wr_data = '0; oe_n = 0; ilv_mode = 0; sleep = 0;
    idle();
    repeat (3) tick();
    rst_n = 1;
    chk("R12 reset valid", {35'd0, rd_valid}, 36'd0);
    cont(0);
    chk("R12 no burst yet", {35'd0, rd_valid}, 36'd0);

    // preload addresses 0..63 in linear bursts with global write
    for (int b = 0; b < 16; b++) begin
      idle(); cstb_n = 0; addr = AW'(4*b); gwr_n = 0; wr_data = pat(4*b); tick();
      chk("R10 write quiet", {35'd0, rd_valid}, 36'd0);
      for (int j = 1; j < 4; j++) begin
        idle(); adv_n = 0; gwr_n = 0; wr_data = pat(4*b + j); tick();
      end
    end

    // interleaved order from 5: 5 4 7 6 then wraps to 5
    ilv_mode = 1;
    prd(5);
    chk("R1 flow-through valid", {35'd0, rd_valid}, 36'd1);
    chk("R1 flow-through data", rd_data, pat(5));
    cont(0); chk("R3 beat1", rd_data, pat(4));
    cont(0); chk("R3 beat2", rd_data, pat(7));
    cont(0); chk("R3 beat3", rd_data, pat(6));
    cont(0); chk("R3 wrap", rd_data, pat(5));

    // linear order from 5: 5 6 7 4
    ilv_mode = 0;
    prd(5);
    cont(0); chk("R4 beat1", rd_data, pat(6));
    cont(0); chk("R4 beat2", rd_data, pat(7));
    cont(0); chk("R4 wrap in group", rd_data, pat(4));

    // suspend
    prd(9);
    cont(1); chk("R5 suspend", rd_data, pat(9));
    cont(0); chk("R5 advance", rd_data, pat(10));

    // controller strobe begins a read; both strobes low also begin
    idle(); cstb_n = 0; addr = 10'd12; tick();
    chk("R6 cstb begin", rd_data, pat(12));
    idle(); pstb_n = 0; cstb_n = 0; addr = 10'd13; tick();
    chk("R6 both strobes", rd_data, pat(13));

    // processor strobe ignores write enables
    idle(); pstb_n = 0; gwr_n = 0; bwe_n = 0; lane_we_n = 4'h0; wr_data = '1;
    addr = 10'd20; tick();
    chk("R7 valid", {35'd0, rd_valid}, 36'd1);
    chk("R7 data", rd_data, pat(20));
    prd(20); chk("R7 unchanged", rd_data, pat(20));

    // byte lanes 0 and 2 written
    idle(); cstb_n = 0; bwe_n = 0; lane_we_n = 4'b1010; wr_data = '1; addr = 10'd30; tick();
    chk("R10 lane write quiet", {35'd0, rd_valid}, 36'd0);
    prd(30);
    chk("R8 lane write", rd_data, pat(30) | {9'h0, 9'h1FF, 9'h0, 9'h1FF});
    idle(); cstb_n = 0; bwe_n = 0; addr = 10'd31; tick();
    chk("R8 no lane is read", rd_data, pat(31));
    idle(); cstb_n = 0; gwr_n = 0; lane_we_n = 4'h0; wr_data = ~pat(32); addr = 10'd32; tick();
    prd(32); chk("R8 global write", rd_data, ~pat(32));

    // deselect held
    idle(); ce1 = 0; pstb_n = 0; addr = 10'd40; tick();
    chk("R9 deselect", {35'd0, rd_valid}, 36'd0);
    idle(); adv_n = 0; gwr_n = 0; wr_data = '0; tick();
    chk("R9 held", {35'd0, rd_valid}, 36'd0);
    idle(); ce0_n = 1; cstb_n = 0; gwr_n = 0; wr_data = '0; addr = 10'd41; tick();
    chk("R9 cstb deselect", {35'd0, rd_valid}, 36'd0);
    prd(40); chk("R9 no write 40", rd_data, pat(40));
    prd(41); chk("R9 no write 41", rd_data, pat(41));

    // asynchronous output enable
    prd(44);
    oe_n = 1; #1;
    chk("R2 valid off", {35'd0, rd_valid}, 36'd0);
    chk("R2 data zero", rd_data, 36'd0);
    oe_n = 0; #1;
    chk("R2 restored", rd_data, pat(44));

    // sleep
    prd(48);
    sleep = 1; #1;
    chk("R11 valid off", {35'd0, rd_valid}, 36'd0);
    idle(); pstb_n = 0; addr = 10'd52; tick();
    idle(); cstb_n = 0; gwr_n = 0; wr_data = '0; addr = 10'd48; tick();
    sleep = 0; #1;
    chk("R11 state kept", rd_data, pat(48));
    idle(); pstb_n = 0; addr = 10'd52; tick();
    chk("R11 wake edge ignored", rd_data, pat(48));
    prd(52); chk("R11 resumed", rd_data, pat(52));
    prd(48); chk("R11 sleep write ignored", rd_data, pat(48));

    idle(); tick();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule